// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs single bus transfers for a 16-bit processor core whose external bus carries a 20-bit address, status and 16-bit data on one shared set of lines at different times. The core presents a request: read or write, memory or I/O space, byte or word, an address, write data, the current interrupt-enable flag and a two-bit segment code. The sequencer then steps through four bus states. It pulses the address-latch strobe while the address is on the lines and lowers the read or write strobe for the data phase. It inserts wait states for as long as the slave holds `ready_i` low, and it hands back read data aligned to the low byte when the transfer is a byte.

Between transfers the block can give the whole bus to an external DMA master. A hold request is sampled every clock. It is granted only when no transfer is in progress, and it takes priority over a request from the core presented in the same cycle. While the grant is up, every bus output is released.

Top module: `bus_cycle_seq`

## Requirements
- R1: Out of reset the block is idle: `ale_o`=0, `rd_no`=`wr_no`=`den_no`=`bhe_no`=1, `ad_oe_o`=0, `hlda_o`=0, `bus_oe_o`=1, `req_ready_o`=1.
- R2: A request accepted at a clock edge (`req_valid_i` and `req_ready_o` both high) makes the next cycle the address state. In it `ale_o`=1 for exactly one clock, `ad_oe_o`=1 and `ad_o` carries the 20-bit address. The address has bit 0 cleared for a word transfer and bits 19..16 forced to 0 for an I/O transfer. `io_m_o` is 1 for I/O and 0 for memory for the whole transfer.
- R3: From the second state to the last state of a transfer, `ad_o[19:16]` carries status: bit 19 = 0, bit 18 = the request's interrupt flag, bits 17..16 = the request's segment code.
- R4: In a read, `rd_no` is low in the second and third states and in every wait state, and high in the last state. Read data is taken from `ad_i` at the edge that leaves the third state or the last wait state. `rdata_valid_o` is high for the single cycle of the last state and carries that data on `rdata_o`.
- R5: In a write, `wr_no` is low in the second and third states and in every wait state, and high in the last state. `ad_oe_o`=1 and `ad_o[15:0]` holds the write data from the second state through the last state.
- R6: `ready_i` is sampled at the end of the third state and of each wait state. While it is 0 a further wait state follows. The last state follows the first cycle in which it is 1.
- R7: For the whole transfer, `bhe_no` together with address bit 0 as driven in the address state gives: 00 for a word, 01 for a byte at an odd address, 10 for a byte at an even address.
- R8: For a byte write, the low byte of the write data is driven on both byte lanes. A byte read returns the upper lane (odd address) or the lower lane (even address) in `rdata_o[7:0]`, with `rdata_o[15:8]`=0. A word read returns all 16 lines.
- R9: `dt_r_o` equals 1 for a write and 0 for a read from the address state through the last state, and is 1 when idle. `den_no` is low from the second state through the last state and high otherwise.
- R10: `hold_i` is sampled every clock. When the block is idle, `hlda_o` rises one clock after `hold_i` is seen high, and it falls one clock after `hold_i` is seen low.
- R11: A hold is never granted inside a transfer. A hold that arrives during a transfer is granted one clock after the block returns to idle. When a hold and a core request arrive in the same idle cycle, the hold wins and no transfer starts.
- R12: While `hlda_o`=1: `bus_oe_o`=0, `ad_oe_o`=0, `req_ready_o`=0, `ale_o`=0, and `rd_no`=`wr_no`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core presents a transfer request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_word_i | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr_i | input | 20 | Transfer address |
| req_wdata_i | input | 16 | Write data (low byte for byte writes) |
| req_iflag_i | input | 1 | Interrupt-enable flag shown in status |
| req_seg_i | input | 2 | Segment code shown in status |
| req_ready_o | output | 1 | Request is taken at this edge |
| rdata_o | output | 16 | Read data, byte reads right-aligned |
| rdata_valid_o | output | 1 | Read data valid, one cycle |
| ready_i | input | 1 | Slave ready, low inserts wait states |
| hold_i | input | 1 | External master asks for the bus |
| hlda_o | output | 1 | Bus granted to external master |
| bus_oe_o | output | 1 | Drive enable for address/status and strobes |
| ad_o | output | 20 | Shared lines: address, then status plus data |
| ad_oe_o | output | 1 | Drive enable for ad_o[15:0] |
| ad_i | input | 16 | Data read from shared lines |
| ale_o | output | 1 | Address latch strobe |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | 1 = I/O transfer, 0 = memory |
| dt_r_o | output | 1 | Buffer direction, 1 = transmit |
| den_no | output | 1 | Data buffer enable, active low |
| bhe_no | output | 1 | Upper byte lane enable, active low |

## Verification
Two functions can meet in one cycle: a hold from an external master and a core request. The bench raises `hold_i` and `req_valid_i` on the same idle cycle and expects the grant to rise with no address strobe ever appearing. It then raises `hold_i` in the second state of a read and expects the transfer to finish all four states with `hlda_o` low, the grant to follow one clock after idle, and the deferred read data still to reach the scoreboard. Wait-state timing is judged by holding the read or write strobe low through each inserted cycle.

// File: rtl/busseq_pkg.sv
package busseq_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int STAT_W = ADDR_W - DATA_W;
  localparam int BYTE_W = DATA_W / 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4
  } bstate_e;

  typedef struct packed {
    logic              wr;
    logic              io;
    logic              word;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              iflag;
    logic [1:0]        seg;
  } breq_t;
endpackage

// File: rtl/busseq_fsm.sv
module busseq_fsm
  import busseq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  breq_t   req_i,
  input  logic    ready_i,
  input  logic    hold_i,
  output bstate_e state_o,
  output breq_t   cur_o,
  output logic    req_ready_o,
  output logic    hlda_o,
  output logic    cap_o
);
  bstate_e st_q, st_d;
  breq_t   cur_q;
  logic    hlda_q;
  logic    accept;

  // hold beats a core request in the same idle cycle
  assign req_ready_o = (st_q == ST_IDLE) && !hlda_q && !hold_i;
  assign accept      = req_valid_i && req_ready_o;
  assign cap_o       = ((st_q == ST_T3) || (st_q == ST_TW)) && ready_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:      st_d = accept ? ST_T1 : ST_IDLE;
      ST_T1:        st_d = ST_T2;
      ST_T2:        st_d = ST_T3;
      ST_T3, ST_TW: st_d = ready_i ? ST_T4 : ST_TW;
      ST_T4:        st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      hlda_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) cur_q <= req_i;
      hlda_q <= hlda_q ? hold_i : (hold_i && (st_q == ST_IDLE));
    end
  end

  assign state_o = st_q;
  assign cur_o   = cur_q;
  assign hlda_o  = hlda_q;

  assert_wait_inserted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_T3 || st_q == ST_TW) && !ready_i) |=> (st_q == ST_TW));
  assert_grant_idle_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_q |-> (st_q == ST_IDLE));
  assert_grant_follows_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_q) |-> $past(hold_i));
endmodule

// File: rtl/busseq_pins.sv
module busseq_pins
  import busseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bstate_e           state_i,
  input  breq_t             cur_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              io_m_o,
  output logic              dt_r_o,
  output logic              den_no,
  output logic              bhe_no,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o
);
  logic              busy, data_ph, strobe_ph;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] lane_wdata, rdata_q;
  logic [STAT_W-1:0] status;

  assign busy      = (state_i != ST_IDLE);
  assign data_ph   = busy && (state_i != ST_T1);
  assign strobe_ph = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_TW);
  assign status    = {1'b0, cur_i.iflag, cur_i.seg};

  always_comb begin
    eff_addr = cur_i.addr;
    if (cur_i.word) eff_addr[0] = 1'b0;
    if (cur_i.io)   eff_addr[ADDR_W-1:DATA_W] = '0;
  end

  assign lane_wdata = cur_i.word ? cur_i.wdata
                                 : {cur_i.wdata[BYTE_W-1:0], cur_i.wdata[BYTE_W-1:0]};

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    if (state_i == ST_T1) begin
      ad_o    = eff_addr;
      ad_oe_o = 1'b1;
    end else if (data_ph) begin
      ad_o    = {status, cur_i.wr ? lane_wdata : {DATA_W{1'b0}}};
      ad_oe_o = cur_i.wr;
    end
  end

  assign ale_o  = (state_i == ST_T1);
  assign rd_no  = !(strobe_ph && !cur_i.wr);
  assign wr_no  = !(strobe_ph && cur_i.wr);
  assign io_m_o = busy && cur_i.io;
  assign dt_r_o = busy ? cur_i.wr : 1'b1;
  assign den_no = !data_ph;
  assign bhe_no = busy ? (!cur_i.word && !cur_i.addr[0]) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (cap_i && !cur_i.wr) begin
      if (cur_i.word)         rdata_q <= ad_i;
      else if (cur_i.addr[0]) rdata_q <= {{BYTE_W{1'b0}}, ad_i[DATA_W-1:BYTE_W]};
      else                    rdata_q <= {{BYTE_W{1'b0}}, ad_i[BYTE_W-1:0]};
    end
  end

  assign rdata_o       = rdata_q;
  assign rdata_valid_o = (state_i == ST_T4) && !cur_i.wr;

  assert_ale_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  assert_strobes_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  assert_rdata_after_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> $past(!rd_no));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import busseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_iflag_i,
  input  logic [1:0]        req_seg_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              hlda_o,
  output logic              bus_oe_o,
  output logic [ADDR_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              io_m_o,
  output logic              dt_r_o,
  output logic              den_no,
  output logic              bhe_no
);
  breq_t   req, cur;
  bstate_e state;
  logic    cap;

  assign req = {req_write_i, req_io_i, req_word_i, req_addr_i,
                req_wdata_i, req_iflag_i, req_seg_i};

  busseq_fsm u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_i(req), .ready_i, .hold_i,
    .state_o(state), .cur_o(cur), .req_ready_o, .hlda_o, .cap_o(cap)
  );

  busseq_pins u_pins (
    .clk_i, .rst_ni, .state_i(state), .cur_i(cur), .cap_i(cap), .ad_i,
    .ad_o, .ad_oe_o, .ale_o, .rd_no, .wr_no, .io_m_o, .dt_r_o, .den_no,
    .bhe_no, .rdata_o, .rdata_valid_o
  );

  assign bus_oe_o = !hlda_o;

  assert_released_on_grant_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (rd_no && wr_no && !ad_oe_o && !ale_o));
endmodule

// File: tb/bus_cycle_seq_tb_top.sv
module bus_cycle_seq_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_io = 0, req_word = 0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic        req_iflag = 0;
  logic [1:0]  req_seg = '0;
  logic        ready = 1, hold = 0;
  logic        req_ready, rdata_valid, hlda, bus_oe, ad_oe, ale, rd_n, wr_n, io_m, dt_r, den_n, bhe_n;
  logic [15:0] rdata;
  logic [19:0] ad_out;
  int          total = 0, bad = 0;
  logic [15:0] exp_q[$];
  logic        done = 0;

  always #10 clk = ~clk;

  bus_cycle_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_io_i(req_io), .req_word_i(req_word), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_iflag_i(req_iflag), .req_seg_i(req_seg),
    .req_ready_o(req_ready), .rdata_o(rdata), .rdata_valid_o(rdata_valid),
    .ready_i(ready), .hold_i(hold), .hlda_o(hlda), .bus_oe_o(bus_oe),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in), .ale_o(ale), .rd_no(rd_n),
    .wr_no(wr_n), .io_m_o(io_m), .dt_r_o(dt_r), .den_no(den_n), .bhe_no(bhe_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: scoreboard pop on every read result
  always @(negedge clk) begin
    if (rst_n && rdata_valid) begin
      if (exp_q.size() == 0) check("R4 unexpected rdata", rdata, 32'hdead);
      else check("R4/R8 rdata", rdata, exp_q.pop_front());
    end
  end

  // driver: one transfer, checking each bus state at the falling edge
  task automatic do_cycle(input logic wr, io, word, input logic [19:0] addr,
                          input logic [15:0] wd, rd_bus, input int waits, input logic hold_mid);
    logic [19:0] ea;
    logic [15:0] lane;
    ea = addr;
    if (word) ea[0] = 1'b0;
    if (io) ea[19:16] = 4'h0;
    lane = word ? wd : {wd[7:0], wd[7:0]};
    if (!wr) exp_q.push_back(word ? rd_bus : {8'h00, addr[0] ? rd_bus[15:8] : rd_bus[7:0]});
    req_valid = 1; req_write = wr; req_io = io; req_word = word;
    req_addr = addr; req_wdata = wd; ready = 1; ad_in = rd_bus;
    @(negedge clk); req_valid = 0;
    check("R2 ale in T1", ale, 1);
    check("R2 address", ad_out, ea);
    check("R2 io_m", io_m, io);
    check("R7 bhe/a0", {bhe_n, ad_out[0]}, word ? 2'b00 : (addr[0] ? 2'b01 : 2'b10));
    check("R9 dt_r", dt_r, wr);
    if (hold_mid) hold = 1;
    @(negedge clk);
    check("R2 ale one clock", ale, 0);
    check("R4/R5 strobes T2", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
    check("R3 status", ad_out[19:16], {1'b0, req_iflag, req_seg});
    check("R9 den", den_n, 0);
    check("R5 data drive", ad_oe, wr);
    if (wr) check("R5/R8 wdata", ad_out[15:0], lane);
    check("R11 no grant mid", hlda, 0);
    ready = (waits == 0);
    @(negedge clk);
    check("R4/R5 strobes T3", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
    for (int k = 0; k < waits; k++) begin
      @(negedge clk);
      check("R6 wait strobe", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
      check("R6 no result yet", rdata_valid, 0);
      check("R2 io_m held", io_m, io);
      ready = (k == waits - 1);
    end
    @(negedge clk);
    check("R4/R5 strobes T4", {rd_n, wr_n}, 2'b11);
    check("R9 den T4", den_n, 0);
    check("R3 status T4", ad_out[19:16], {1'b0, req_iflag, req_seg});
    check("R11 no grant T4", hlda, 0);
    if (wr) check("R5 wdata T4", ad_out[15:0], lane);
    check("R4 rdata_valid", rdata_valid, !wr);
    ready = 1;
    @(negedge clk);
    check("R9 idle den/dt_r", {den_n, dt_r}, 2'b11);
    check("R11 ready in idle", req_ready, !hold_mid);
    check("R11 grant after idle", hlda, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ale", ale, 0);
    check("R1 strobes", {rd_n, wr_n, den_n, bhe_n}, 4'hf);
    check("R1 ad_oe", ad_oe, 0);
    check("R1 hold/oe/ready", {hlda, bus_oe, req_ready}, 3'b011);

    req_iflag = 1; req_seg = 2'b10;
    do_cycle(0, 0, 1, 20'hA1234, 16'h0, 16'hBEEF, 0, 0);
    do_cycle(1, 0, 1, 20'h3C0F1, 16'h5A6B, 16'h0, 0, 0);
    req_iflag = 0; req_seg = 2'b01;
    do_cycle(0, 0, 0, 20'h12345, 16'h0, 16'hC3D4, 2, 0);
    do_cycle(0, 0, 0, 20'h12344, 16'h0, 16'hC3D4, 0, 0);
    do_cycle(1, 1, 0, 20'hF8003, 16'h77E1, 16'h0, 3, 0);
    req_seg = 2'b11;
    do_cycle(0, 1, 1, 20'h9ABCE, 16'h0, 16'h0F1E, 1, 0);

    // hold and request in the same idle cycle: hold wins (R11, R12)
    hold = 1; req_valid = 1; req_write = 0; req_addr = 20'h00010; req_word = 1;
    @(negedge clk);
    check("R10 grant one clock after hold", hlda, 1);
    check("R12 bus released", {bus_oe, ad_oe, req_ready}, 3'b000);
    check("R11 no transfer started", ale, 0);
    @(negedge clk);
    check("R12 still no transfer", {ale, rd_n, wr_n}, 3'b011);
    req_valid = 0; hold = 0;
    @(negedge clk);
    check("R10 grant drops", hlda, 0);
    check("R10 bus back", bus_oe, 1);

    // hold arriving inside a read is deferred (R11)
    req_iflag = 1; req_seg = 2'b00;
    do_cycle(0, 0, 1, 20'h44446, 16'h0, 16'h1357, 1, 1);
    @(negedge clk);
    check("R11 deferred grant", hlda, 1);
    check("R12 released", bus_oe, 0);
    hold = 0;
    @(negedge clk);
    check("R10 release after hold low", hlda, 0);
    do_cycle(1, 0, 0, 20'h44447, 16'h00AB, 16'h0, 0, 0);

    @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    done = 1;
    finish_up();
  end
endmodule